// File: doc/BRIEF.md
# Aperture Remap Translator

This block sits on the address path of a bridge and redirects accesses that land inside a power-of-two address window, the aperture, to arbitrary 4 KB physical pages. Software places the window with a base register, picks its size with a 3-bit code, and points the block at a flat table of 32-bit page entries held in system memory. For each request inside the enabled window, the block computes the page number, reads the matching entry through a one-outstanding memory read port, and returns a 40-bit physical address. Requests outside the window go back unchanged, flagged as a miss.

The last good translation is kept in a single cached slot tagged by page number, so repeated accesses to one page answer without touching memory. Software drops that slot by writing a self-clearing command bit, which it can poll until it reads back zero. An entry that is not marked valid, a memory read error, or a needed fetch while fetches are disabled produces a fault response and sets a sticky error flag.

Top module: `apx_remap`

## Requirements
- R1: After reset, all four configuration words read 0, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: Configuration word 0 (control) keeps bits 6:0, word 1 (window base) keeps bits 14:0, word 2 (table base) keeps bits 31:4, and all other bits read 0. Word 3 reads {error flag at bit 1, invalidate pending at bit 0}.
- R3: When control bit 0 (enable) is 0, or the size code in control bits 3:1 is 7, a request gets a response one cycle after it is accepted, with `resp_addr` equal to the request address, `resp_miss`=1, and no memory read.
- R4: A request inside the window that misses the cached slot raises `mem_req_valid` for exactly one cycle, the cycle after acceptance. The read address is {table word[31:4], 12'b0} + 4 × ((request − {base word[14:0], 25'b0}) >> 12).
- R5: One cycle after `mem_rsp_valid`, a valid entry E produces `resp_addr` = {E[11:4], E[31:12], request[11:0]}, with miss and fault both 0. Entry bit 0 means valid.
- R6: The window spans base to base + (32 MB << size code) − 1. The last byte of the window translates, and the first byte past the end, or the byte just below base, is a miss.
- R7: A request to the same page as the last successful fetch returns the cached translation one cycle after acceptance, with no memory read.
- R8: An entry with bit 0 clear, or a read that returns with `mem_rsp_err`, yields `resp_fault`=1 with `resp_addr`=0 and sets word 3 bit 1. Writing 1 to word 3 bit 1 clears that flag.
- R9: With control bit 6 set, a request that would need a fetch faults one cycle after acceptance without a memory read and sets word 3 bit 1. A request that hits the cached slot is still translated.
- R10: Writing 1 to word 3 bit 0 makes that bit read 1 on the following cycle and 0 one cycle later. The cached slot is then empty, so the next request to that page fetches again.
- R11: Control bit 4 set makes requests with `req_io`=0 pass through as misses. Control bit 5 does the same for requests with `req_io`=1. Requests from the other side are still translated.
- R12: `req_ready` is 0 from the cycle the memory read is issued until its response has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select (0 control, 1 base, 2 table, 3 cache) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected word |
| req_valid | input | 1 | Translation request |
| req_io | input | 1 | Request comes from the I/O side (1) or the CPU side (0) |
| req_addr | input | 40 | Bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Response pulse |
| resp_addr | output | 40 | Translated or passed-through address |
| resp_miss | output | 1 | Address was not remapped |
| resp_fault | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Entry read request pulse |
| mem_req_addr | output | 40 | Entry address |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 32 | Entry contents |
| mem_rsp_err | input | 1 | Entry read failed |

## Verification
Requests are sent inside the window, just below it, at its last byte and first byte past its end under two size codes, and with the block disabled or set to the unusable size code. These tell a correct window test apart from off-by-one and wrong-shift mistakes. Pages are revisited after a fetch, after an invalidate and with fetches disabled, which separates a true cached hit from a refetch. Entries generated from their own addresses, an entry with bit 0 clear, and an injected read error show whether the entry fields are put back in the right order and whether faults are kept apart from good responses. CPU-side and I/O-side requests are sent under each side-disable bit.

// File: rtl/apx_remap.sv
`timescale 1ns/1ps
module apx_remap (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic        req_io,
  input  logic [39:0] req_addr,
  output logic        req_ready,
  output logic        resp_valid,
  output logic [39:0] resp_addr,
  output logic        resp_miss,
  output logic        resp_fault,
  output logic        mem_req_valid,
  output logic [39:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err
);
  localparam int PG_SH = 12;
  localparam int WIN_SH = 25;
  localparam int IDX_W = 40 - PG_SH;

  logic [6:0]       ctl;
  logic [14:0]      win_base;
  logic [27:0]      tbl_base;
  logic             inval_pend, ent_err;
  logic             busy;
  logic             slot_vld;
  logic [IDX_W-1:0] slot_tag, slot_frame;
  logic [IDX_W-1:0] held_idx;
  logic [PG_SH-1:0] held_off;

  logic [39:0]      base_pa, offs, lim_mask, ent_pa;
  logic [5:0]       win_sh;
  logic [IDX_W-1:0] idx;
  logic             side_ok, in_win, slot_hit, accept, bad_ent;

  assign base_pa  = {win_base, 25'd0};
  assign offs     = req_addr - base_pa;
  assign win_sh   = 6'(WIN_SH) + {3'd0, ctl[3:1]};
  assign lim_mask = ~((40'd1 << win_sh) - 40'd1);
  assign side_ok  = req_io ? !ctl[5] : !ctl[4];
  assign in_win   = ctl[0] && (ctl[3:1] != 3'd7) && (req_addr >= base_pa)
                    && ((offs & lim_mask) == 40'd0) && side_ok;
  assign idx      = offs[39:PG_SH];
  assign ent_pa   = {tbl_base, 12'd0} + {10'd0, idx, 2'b00};
  assign slot_hit = slot_vld && (slot_tag == idx);
  assign req_ready = !busy;
  assign accept   = req_valid && !busy;
  assign bad_ent  = mem_rsp_err || !mem_rsp_data[0];

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {25'd0, ctl};
      2'd1:    cfg_rdata = {17'd0, win_base};
      2'd2:    cfg_rdata = {tbl_base, 4'd0};
      default: cfg_rdata = {30'd0, ent_err, inval_pend};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0; win_base <= '0; tbl_base <= '0;
      inval_pend <= 1'b0; ent_err <= 1'b0; busy <= 1'b0;
      slot_vld <= 1'b0; slot_tag <= '0; slot_frame <= '0;
      held_idx <= '0; held_off <= '0;
      resp_valid <= 1'b0; resp_addr <= '0; resp_miss <= 1'b0; resp_fault <= 1'b0;
      mem_req_valid <= 1'b0; mem_req_addr <= '0;
    end else begin
      resp_valid    <= 1'b0;
      mem_req_valid <= 1'b0;
      if (inval_pend) begin
        inval_pend <= 1'b0;
        slot_vld   <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: ctl      <= cfg_wdata[6:0];
          2'd1: win_base <= cfg_wdata[14:0];
          2'd2: tbl_base <= cfg_wdata[31:4];
          default: begin
            if (cfg_wdata[0]) inval_pend <= 1'b1;
            if (cfg_wdata[1]) ent_err <= 1'b0;
          end
        endcase
      end
      if (!busy) begin
        if (accept) begin
          if (!in_win) begin
            resp_valid <= 1'b1; resp_addr <= req_addr;
            resp_miss <= 1'b1; resp_fault <= 1'b0;
          end else if (slot_hit) begin
            resp_valid <= 1'b1; resp_addr <= {slot_frame, req_addr[PG_SH-1:0]};
            resp_miss <= 1'b0; resp_fault <= 1'b0;
          end else if (ctl[6]) begin
            resp_valid <= 1'b1; resp_addr <= '0;
            resp_miss <= 1'b0; resp_fault <= 1'b1;
            ent_err <= 1'b1;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_addr  <= ent_pa;
            held_idx      <= idx;
            held_off      <= req_addr[PG_SH-1:0];
            busy          <= 1'b1;
          end
        end
      end else if (mem_rsp_valid) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_miss  <= 1'b0;
        if (bad_ent) begin
          resp_addr  <= '0;
          resp_fault <= 1'b1;
          ent_err    <= 1'b1;
        end else begin
          resp_addr  <= {mem_rsp_data[11:4], mem_rsp_data[31:12], held_off};
          resp_fault <= 1'b0;
          slot_vld   <= 1'b1;
          slot_tag   <= held_idx;
          slot_frame <= {mem_rsp_data[11:4], mem_rsp_data[31:12]};
        end
      end
    end
  end
endmodule

module apx_remap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [1:0]  cfg_addr,
  input logic [31:0] cfg_wdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic [39:0] resp_addr,
  input logic        resp_miss,
  input logic        resp_fault,
  input logic        mem_req_valid,
  input logic        mem_rsp_valid,
  input logic        inval_pend
);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  a_r12_stall_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  a_r12_no_fetch_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_rsp_valid) |=> !resp_valid);
  a_r3_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot0({resp_miss, resp_fault}));
  a_r8_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_addr == 40'd0));
  a_r5_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid)));
  a_r10_inval_done: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_pend && !(cfg_we && cfg_addr == 2'd3 && cfg_wdata[0])) |=> !inval_pend);
endmodule

bind apx_remap apx_remap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .req_valid(req_valid), .req_ready(req_ready), .resp_valid(resp_valid),
  .resp_addr(resp_addr), .resp_miss(resp_miss), .resp_fault(resp_fault),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid), .inval_pend(inval_pend)
);

// File: tb/apx_remap_tb_top.sv
`timescale 1ns/1ps
module apx_remap_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [1:0] cfg_addr = '0; logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0, req_io = 1'b0; logic [39:0] req_addr = '0;
  logic req_ready, resp_valid, resp_miss, resp_fault, mem_req_valid;
  logic [39:0] resp_addr, mem_req_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0; logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  apx_remap dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [41:0] exp_q[$];
  string       tag_q[$];
  logic [39:0] fetch_q[$];

  logic [31:0] sh_ctl = 0, sh_base = 0, sh_tbl = 0;
  bit          cv = 0; logic [27:0] cidx = 0, cframe = 0;
  logic [39:0] bad_ea = '1; bit rsp_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ent_of(input logic [39:0] ea);
    return {ea[21:2] ^ 20'hA5A5A, ea[9:2] ^ 8'h3C, 2'b00, 1'b1, ea != bad_ea};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: sh_ctl = d;
      2'd1: sh_base = d;
      2'd2: sh_tbl = d;
      default: if (d[0]) cv = 0;
    endcase
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    cfg_addr = a; #1; v = cfg_rdata;
  endtask

  task automatic lookup(input logic [39:0] a, input bit io, input string tag);
    logic [39:0] base, size, ea; logic [27:0] idx; logic [31:0] e; bit hit;
    base = {sh_base[14:0], 25'd0};
    size = 40'h200_0000 << sh_ctl[3:1];
    hit  = sh_ctl[0] && sh_ctl[3:1] != 7 && a >= base && (a - base) < size
           && (io ? !sh_ctl[5] : !sh_ctl[4]);
    idx  = 28'((a - base) >> 12);
    ea   = {sh_tbl[31:4], 12'd0} + {10'd0, idx, 2'b00};
    if (!hit) exp_q.push_back({a, 2'b10});
    else if (cv && cidx == idx) exp_q.push_back({cframe, a[11:0], 2'b00});
    else if (sh_ctl[6]) exp_q.push_back({40'd0, 2'b01});
    else begin
      fetch_q.push_back(ea);
      e = ent_of(ea);
      if (rsp_err || !e[0]) exp_q.push_back({40'd0, 2'b01});
      else begin
        exp_q.push_back({e[11:4], e[31:12], a[11:0], 2'b00});
        cv = 1; cidx = idx; cframe = {e[11:4], e[31:12]};
      end
    end
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_io = io;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0 || fetch_q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (resp_valid) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected response", {22'd0, resp_addr, resp_miss, resp_fault}, 0);
        else begin
          logic [41:0] x; string t;
          x = exp_q.pop_front(); t = tag_q.pop_front();
          chk({resp_addr, resp_miss, resp_fault} == x, t, {22'd0, resp_addr, resp_miss, resp_fault}, {22'd0, x});
        end
      end
    end
  end

  initial begin : memory
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [39:0] ea;
        ea = mem_req_addr;
        chk(!req_ready, "R12 ready low during fetch", req_ready, 0);
        if (fetch_q.size() == 0) chk(0, "R7 unexpected fetch", ea, 0);
        else begin
          logic [39:0] x;
          x = fetch_q.pop_front();
          chk(ea == x, "R4 fetch address", ea, x);
        end
        @(negedge clk);
        chk(!mem_req_valid, "R4 fetch pulse one cycle", mem_req_valid, 0);
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = ent_of(ea); mem_rsp_err = rsp_err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [39:0] BASE = 40'h00_8000_0000;

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk(v == 0, "R1 reset config word", v, 0);
    end
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset outputs",
        {req_ready, resp_valid, mem_req_valid}, 3'b100);

    wr(0, 32'hFFFF_FFFF); rd(0, v); chk(v == 32'h7F, "R2 control mask", v, 32'h7F);
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk(v == 32'h7FFF, "R2 base mask", v, 32'h7FFF);
    wr(2, 32'hFFFF_FFFF); rd(2, v); chk(v == 32'hFFFF_FFF0, "R2 table mask", v, 32'hFFFF_FFF0);
    wr(3, 32'hFFFF_FFFF); rd(3, v); chk(v == 32'h1, "R10 invalidate pending", v, 1);
    @(negedge clk); rd(3, v); chk(v == 32'h0, "R10 invalidate self-clears", v, 0);

    wr(1, 32'h40); wr(2, 32'h1234_5670);
    wr(0, 32'h0);                lookup(BASE + 40'h5123, 0, "R3 disabled passes through");
    wr(0, 32'h1 | (7 << 1));     lookup(BASE + 40'h5123, 0, "R3 size code 7 passes through");

    wr(0, 32'h1 | (4 << 1));
    lookup(BASE + 40'h5123, 0, "R5 first translation");
    lookup(BASE + 40'h5FFC, 0, "R7 cached page");
    lookup(BASE + 40'h3_7008, 1, "R5 second page");
    lookup(BASE + 40'h1FFF_FFFF, 0, "R6 last byte 512MB");
    lookup(BASE + 40'h2000_0000, 0, "R6 past end 512MB");
    lookup(BASE - 40'h1, 0, "R6 below base");
    wr(0, 32'h1 | (0 << 1));
    lookup(BASE + 40'h01FF_FFF0, 0, "R6 last page 32MB");
    lookup(BASE + 40'h0200_0000, 0, "R6 past end 32MB");

    wr(0, 32'h1 | (4 << 1));
    bad_ea = {sh_tbl[31:4], 12'd0} + 40'h4 * 40'h77;
    lookup(BASE + 40'h77_010, 0, "R8 invalid entry faults");
    rd(3, v); chk(v == 32'h2, "R8 error flag set", v, 2);
    wr(3, 32'h2); rd(3, v); chk(v == 32'h0, "R8 error flag cleared", v, 0);
    rsp_err = 1;
    lookup(BASE + 40'h88_000, 0, "R8 read error faults");
    rsp_err = 0;
    rd(3, v); chk(v == 32'h2, "R8 error flag after read error", v, 2);
    wr(3, 32'h2);

    lookup(BASE + 40'h9_444, 0, "R5 fill before probe test");
    wr(0, 32'h1 | (4 << 1) | 32'h40);
    lookup(BASE + 40'h9_888, 0, "R9 cached still served");
    lookup(BASE + 40'hA_000, 0, "R9 walk disabled faults");
    rd(3, v); chk(v == 32'h2, "R9 error flag set", v, 2);
    wr(3, 32'h2);

    wr(0, 32'h1 | (4 << 1));
    wr(3, 32'h1);
    @(negedge clk);
    lookup(BASE + 40'h9_100, 0, "R10 refetch after invalidate");

    wr(0, 32'h1 | (4 << 1) | 32'h10);
    lookup(BASE + 40'hB_004, 0, "R11 cpu side disabled");
    lookup(BASE + 40'hB_008, 1, "R11 io side still translated");
    wr(0, 32'h1 | (4 << 1) | 32'h20);
    lookup(BASE + 40'hC_00C, 1, "R11 io side disabled");
    lookup(BASE + 40'hC_010, 0, "R11 cpu side still translated");

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && fetch_q.size() == 0, "R7 no leftover expectations",
        exp_q.size() + fetch_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule